// File: doc/BRIEF.md
# Key-Gated Indirect Configuration Register File

This block is the device side of a byte-wide, I/O-mapped configuration port for a disk-controller chipset. Three port addresses are decoded: a base (lock) port, an index port four above it and a data port eight above it. A small state machine guards the register bank. Writing one of four key values to the base port opens it (transition KEY_WRITE, state ST_OPEN). Writing any other value closes it again (transition OTHER_WRITE, state ST_LOCKED). Reading the base port always returns the byte last written there, so software can confirm an unlock by reading its key back.

While the bank is open, software writes a register number to the index port and then reads or writes that register through the data port. Register 0x00 carries a fixed identification code. Reading the index port after selecting register 0x01 reports a health bit. Four groups of four timing registers, one group per drive, are driven straight out of the storage flops to downstream strobe-generation logic. Every bank register loads a defined default at reset.

Reads are registered: a read strobe is answered one clock later with `rd_valid` and `rdata`.

Top module: `cfgport_top`

## Requirements
- R1: The base port address is chosen at elaboration by `BASE_SEL` (0→0x074, 1→0x0F4, 2→0x034, 3→0x0E4). The index port is at base+4 and the data port is at base+8.
- R2: A base-port write of any value from 0x30 to 0x33 opens the bank (ST_OPEN). A later base-port read returns that key.
- R3: A base-port write of any other value locks the bank (ST_LOCKED). A base-port read always returns the last byte written to the base port.
- R4: While locked, index-port and data-port writes change nothing, and index-port and data-port reads return 0xFF.
- R5: A read strobe in one cycle gives `rd_valid`=1 and `rdata` in the next cycle. Reads of any address other than the three ports return 0x00.
- R6: Register 0x00 reads 0x50 (identification code 0x5 in bits 7:4). Writes to it are dropped.
- R7: While open, an index-port read returns 0x01 (health bit in bit 0) when the index is 0x01, and returns 0x00 for any other index.
- R8: Reset loads 0x0F into 0x01, 0x2B into 0x07, 0x0F into 0x0A, 0xFF into 0x34 and 0x03 into 0x35. Every other bank register is loaded with 0x00.
- R9: The bank is 0x01–0x07, 0x0A and 0x25–0x35. Data-port reads of any other index (other than 0x00) return 0x00, and writes to such an index are dropped.
- R10: Drive d's timing bytes are `drv_timing[d*32 + k*8 +: 8]` for k=0..3, taken from registers {0x03,0x26,0x04,0x27} (d=0), {0x05,0x28,0x06,0x29} (d=1), {0x2B,0x30,0x2C,0x31} (d=2) and {0x2D,0x32,0x2E,0x33} (d=3). Each byte shows a data write from the clock edge that performs that write.
- R11: After reset the bank is locked, the base readback and the index are 0x00, and all timing outputs hold 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 10 | Port address of the access |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read answer, one cycle after rd_en |
| drv_timing | output | 128 | Four timing bytes for each of four drives |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle, and that each strobe lasts exactly one clock for each access. The stimulus keeps to this because every access passes through one write task or one read task. Each task raises a single strobe for one cycle and drops it before the next access starts. The assertions also assume that the address and data are stable across the sampling edge. The bench changes inputs only on falling edges, so this holds.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

    typedef enum logic [0:0] {
        ST_LOCKED = 1'b0,
        ST_OPEN   = 1'b1
    } lock_state_t;

    localparam int BYTE_W         = 8;
    localparam int NUM_DRIVES     = 4;
    localparam int REGS_PER_DRIVE = 4;
    localparam logic [7:0] ID_VALUE = 8'h50;

    function automatic logic [9:0] base_for(input int sel);
        case (sel)
            1:       return 10'h0F4;
            2:       return 10'h034;
            3:       return 10'h0E4;
            default: return 10'h074;
        endcase
    endfunction

    function automatic logic is_key(input logic [7:0] v);
        return v[7:2] == 6'b001100;
    endfunction

    function automatic logic in_map(input logic [7:0] a);
        return ((a >= 8'h01) && (a <= 8'h07)) || (a == 8'h0A) ||
               ((a >= 8'h25) && (a <= 8'h35));
    endfunction

    function automatic logic [7:0] reset_value(input logic [7:0] a);
        case (a)
            8'h01:   return 8'h0F;
            8'h07:   return 8'h2B;
            8'h0A:   return 8'h0F;
            8'h34:   return 8'hFF;
            8'h35:   return 8'h03;
            default: return 8'h00;
        endcase
    endfunction

    // slot = drive * REGS_PER_DRIVE + position inside the group
    function automatic logic [7:0] timing_reg(input int slot);
        case (slot)
            0:  return 8'h03;  1:  return 8'h26;  2:  return 8'h04;  3:  return 8'h27;
            4:  return 8'h05;  5:  return 8'h28;  6:  return 8'h06;  7:  return 8'h29;
            8:  return 8'h2B;  9:  return 8'h30;  10: return 8'h2C;  11: return 8'h31;
            12: return 8'h2D;  13: return 8'h32;  14: return 8'h2E;  default: return 8'h33;
        endcase
    endfunction

endpackage

// File: rtl/key_lock_fsm.sv
module key_lock_fsm
    import cfgport_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_wr,
    input  logic [7:0] wdata,
    output logic       unlocked,
    output logic [7:0] base_q
);

    lock_state_t state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            base_q  <= 8'h00;
        end else begin
            state_q <= state_d;
            if (base_wr) base_q <= wdata;
        end
    end

    // transitions: KEY_WRITE opens, OTHER_WRITE closes
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: if (base_wr && is_key(wdata))  state_d = ST_OPEN;
            ST_OPEN:   if (base_wr && !is_key(wdata)) state_d = ST_LOCKED;
            default:   state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_OPEN: unlocked = 1'b1;
            default: unlocked = 1'b0;
        endcase
    end

    p_unlock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && is_key(wdata)) |=> (unlocked && base_q == $past(wdata)));

    p_relock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (base_wr && !is_key(wdata)) |=> (!unlocked && base_q == $past(wdata)));

endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfgport_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [7:0]                   waddr,
    input  logic [7:0]                   wdata,
    output logic [DEPTH-1:0][BYTE_W-1:0] mem_q
);

    logic hit;
    always_comb hit = in_map(waddr) && (int'(waddr) < DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= reset_value(8'(i));
        end else if (we && hit) begin
            mem_q[waddr[AW-1:0]] <= wdata;
        end
    end

    p_drop_outside_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !in_map(waddr)) |=> $stable(mem_q));

endmodule

// File: rtl/timing_tap.sv
module timing_tap
    import cfgport_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH),
    localparam int OUT_W = NUM_DRIVES * REGS_PER_DRIVE * BYTE_W
) (
    input  logic [DEPTH-1:0][BYTE_W-1:0] mem_i,
    output logic [OUT_W-1:0]             drv_timing
);

    for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
        for (genvar k = 0; k < REGS_PER_DRIVE; k++) begin : g_byte
            localparam logic [7:0] REG_A = timing_reg(d * REGS_PER_DRIVE + k);
            assign drv_timing[(d*REGS_PER_DRIVE + k)*BYTE_W +: BYTE_W] = mem_i[REG_A[AW-1:0]];
        end
    end

endmodule

// File: rtl/cfgport_top.sv
module cfgport_top
    import cfgport_pkg::*;
#(
    parameter int BASE_SEL = 0,
    parameter int ADDR_W   = 10,
    parameter int DEPTH    = 64,
    localparam int AW      = $clog2(DEPTH),
    localparam int OUT_W   = NUM_DRIVES * REGS_PER_DRIVE * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              rd_valid,
    output logic [OUT_W-1:0]  drv_timing
);

    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(base_for(BASE_SEL));
    localparam logic [ADDR_W-1:0] IDX_A  = BASE_A + ADDR_W'(4);
    localparam logic [ADDR_W-1:0] DAT_A  = BASE_A + ADDR_W'(8);

    logic base_hit, idx_hit, dat_hit;
    logic unlocked;
    logic [7:0] base_q, idx_q, rd_mux;
    logic [DEPTH-1:0][BYTE_W-1:0] bank_q;

    always_comb begin
        base_hit = (io_addr == BASE_A);
        idx_hit  = (io_addr == IDX_A);
        dat_hit  = (io_addr == DAT_A);
    end

    key_lock_fsm u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_wr  (wr_en && base_hit),
        .wdata    (wdata),
        .unlocked (unlocked),
        .base_q   (base_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                           idx_q <= 8'h00;
        else if (wr_en && idx_hit && unlocked) idx_q <= wdata;
    end

    cfg_bank #(.DEPTH(DEPTH)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en && dat_hit && unlocked),
        .waddr (idx_q),
        .wdata (wdata),
        .mem_q (bank_q)
    );

    timing_tap #(.DEPTH(DEPTH)) u_tap (
        .mem_i      (bank_q),
        .drv_timing (drv_timing)
    );

    always_comb begin
        rd_mux = 8'h00;
        if (base_hit) begin
            rd_mux = base_q;
        end else if (idx_hit) begin
            if (!unlocked)          rd_mux = 8'hFF;
            else if (idx_q == 8'h01) rd_mux = 8'h01;
        end else if (dat_hit) begin
            if (!unlocked)          rd_mux = 8'hFF;
            else if (idx_q == 8'h00) rd_mux = ID_VALUE;
            else if (in_map(idx_q) && (int'(idx_q) < DEPTH)) rd_mux = bank_q[idx_q[AW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= 8'h00;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rdata <= rd_mux;
        end
    end

    p_read_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_locked_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dat_hit && !unlocked) |=> $stable(bank_q));

    p_locked_index_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx_hit && !unlocked) |=> $stable(idx_q));

    p_id_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && dat_hit && unlocked && idx_q == 8'h00) |=> (rdata[7:4] == 4'h5));

    p_timing_update_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && dat_hit && unlocked && idx_q == 8'h03) |=> (drv_timing[7:0] == $past(wdata)));

endmodule

// File: tb/cfgport_top_test.sv
`timescale 1ns/1ps
module cfgport_top_test;

    localparam logic [9:0] BASE = 10'h074;
    localparam logic [9:0] IDX  = 10'h078;
    localparam logic [9:0] DAT  = 10'h07C;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [9:0]   io_addr = '0;
    logic         wr_en = 1'b0;
    logic         rd_en = 1'b0;
    logic [7:0]   wdata = '0;
    logic [7:0]   rdata;
    logic         rd_valid;
    logic [127:0] drv_timing;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    // bench-side copy of the timing map from R10
    logic [7:0] tmap [16] = '{8'h03,8'h26,8'h04,8'h27, 8'h05,8'h28,8'h06,8'h29,
                              8'h2B,8'h30,8'h2C,8'h31, 8'h2D,8'h32,8'h2E,8'h33};

    always #4 clk = ~clk;

    cfgport_top uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .drv_timing(drv_timing)
    );

    task automatic wr(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        io_addr = a; rd_en = 1'b1;
        exp_q.push_back(e); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk(input logic [127:0] act, input logic [127:0] e, input string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, e);
        end
    endtask

    // monitor: compares each read answer against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R5: unexpected rd_valid actual=%h expected=none", rdata);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rdata !== e) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", t, rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [127:0] tv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk(drv_timing, '0, "R11 timing after reset");
        rd(BASE, 8'h00, "R11 base readback");
        rd(DAT, 8'hFF, "R4 R11 locked data read");
        rd(IDX, 8'hFF, "R4 locked index read");

        // R2 unlock, R1 port offsets; off-by-one base must not unlock
        wr(BASE + 10'd1, 8'h31);
        rd(DAT, 8'hFF, "R1 neighbour port no unlock");
        wr(BASE, 8'h31);
        rd(BASE, 8'h31, "R2 key readback");

        // R6 identification
        wr(IDX, 8'h00);
        rd(DAT, 8'h50, "R6 id code");
        wr(DAT, 8'h12);
        rd(DAT, 8'h50, "R6 id write dropped");

        // R7 health bit
        wr(IDX, 8'h01);
        rd(IDX, 8'h01, "R7 health");
        // R8 defaults
        rd(DAT, 8'h0F, "R8 reg01");
        wr(IDX, 8'h07); rd(DAT, 8'h2B, "R8 reg07");
        rd(IDX, 8'h00, "R7 other index");
        wr(IDX, 8'h0A); rd(DAT, 8'h0F, "R8 reg0A");
        wr(IDX, 8'h34); rd(DAT, 8'hFF, "R8 reg34");
        wr(IDX, 8'h35); rd(DAT, 8'h03, "R8 reg35");
        wr(IDX, 8'h02); rd(DAT, 8'h00, "R8 reg02");

        // R9 outside the bank
        wr(IDX, 8'h08); wr(DAT, 8'h55); rd(DAT, 8'h00, "R9 hole 08");
        wr(IDX, 8'h40); wr(DAT, 8'h77); rd(DAT, 8'h00, "R9 beyond 40");

        // R10 timing map, update right after the writing edge
        tv = '0;
        for (int s = 0; s < 16; s++) begin
            logic [7:0] v;
            v = 8'h80 + 8'(s * 7);
            wr(IDX, tmap[s]);
            wr(DAT, v);
            tv[s*8 +: 8] = v;
            chk(drv_timing, tv, "R10 timing byte");
        end
        wr(IDX, 8'h26); rd(DAT, tv[15:8], "R10 readback 26");

        // R5 undecoded port
        rd(BASE + 10'd1, 8'h00, "R5 undecoded port");

        // R3 relock, R4 locked writes ignored
        wr(IDX, 8'h33);
        wr(BASE, 8'h55);
        rd(BASE, 8'h55, "R3 other readback");
        rd(DAT, 8'hFF, "R3 R4 locked after other");
        wr(DAT, 8'h00);
        wr(IDX, 8'h01);
        chk(drv_timing, tv, "R4 timing held while locked");
        wr(BASE, 8'h34);
        rd(DAT, 8'hFF, "R3 0x34 not a key");
        wr(BASE, 8'h2F);
        rd(DAT, 8'hFF, "R3 0x2F not a key");
        wr(BASE, 8'h33);
        rd(DAT, tv[127:120], "R4 data write ignored");
        rd(IDX, 8'h00, "R4 index write ignored");
        wr(BASE, 8'h30);
        rd(BASE, 8'h30, "R2 key 30");
        wr(BASE, 8'h32);
        rd(DAT, tv[127:120], "R2 key 32 open");

        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R5: actual=%0d pending expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule